// File: doc/BRIEF.md
# SPI Serial Read-Only Memory Slave

This block is the device end of a serial read-only memory on a four-wire SPI bus, with a fifth input that pauses a transfer. A fast system clock oversamples the serial pins. The block takes an 8-bit opcode and then serves one of three commands. The first returns a fixed three-byte identity. The second is a plain read, which streams data straight after a 24-bit address. The third is a fast read, which inserts one ignored byte between the address and the data. While data flows, the address advances by one after every byte and wraps from the top of the 16M-byte space to zero. One command can therefore stream the whole array.

The array has no storage. Each byte is the XOR of the three bytes of its own address, so any observer can predict it. An opcode the block does not know sends it into standby until the next select. Raising chip select at any point ends the operation. A hold request pauses the transfer without deselecting the device. SO is given as a data bit with a separate output enable, and the enable low stands for high impedance.

Top module: `spi_rom_slave`

## Requirements
- R1: After reset and whenever chip select is high, `so_oe` is 0.
- R2: Opcode 0x9F returns the bytes 0xC2, 0x05, 0x18 in that order, each most significant bit first, on SO.
- R3: Opcode 0x03 takes a 24-bit address, high byte first and MSB first. The first data bit is driven on the SCLK falling edge after the last address bit. Byte value = A[7:0] ^ A[15:8] ^ A[23:16].
- R4: Opcode 0x0B takes the same address followed by one don't-care byte. Data starts on the falling edge after the last bit of that byte.
- R5: The address increments after each output byte and wraps from 0xFFFFFF to 0x000000.
- R6: Any other opcode puts the block in standby. SO stays disabled and SI and SCLK are ignored until the next chip-select falling edge.
- R7: Raising chip select during any phase releases SO within a few system clocks. The next selection starts a fresh opcode.
- R8: SI is sampled on SCLK rising edges and SO changes on falling edges. Operation is identical with SCLK idling low or idling high.
- R9: While a hold is active, SO is disabled, SCLK and SI are ignored, and after release the transfer continues at the bit where it stopped.
- R10: A hold begins or ends only while SCLK is low. A HOLD# change made while SCLK is high takes effect at the next SCLK low level.
- R11: Raising chip select during a hold clears both the hold and the command state. A following command runs normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the SCLK rate |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the bus master |
| si | input | 1 | Serial data into the block |
| cs_n | input | 1 | Chip select, active low |
| hold_n | input | 1 | Pause request, active low |
| so_data | output | 1 | Serial data bit out |
| so_oe | output | 1 | Drive enable for SO; 0 means high impedance |

## Verification
The hold request and an SCLK edge can fall into the same synchronised cycle. In one case HOLD# drops while SCLK is high, so the falling edge that shifts out the next bit is also the moment the hold begins. In the other case HOLD# rises while SCLK is high, so the falling edge that ends the hold must not be counted as a shift. The bench provokes both during fast-read data in each SCLK mode. It checks that SO is disabled only for the intended span. The byte stream seen after release must continue without a lost or repeated bit, and the scoreboard judges this against the address-derived expected bytes.

// File: rtl/spi_rom_pkg.sv
package spi_rom_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPCODE,
    ST_ADDR,
    ST_DUMMY,
    ST_DATA,
    ST_STANDBY
  } eng_state_t;

  localparam logic [7:0] OP_IDENT = 8'h9F;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_FAST  = 8'h0B;

endpackage

// File: rtl/pin_sync.sv
// Multi-stage synchroniser for a group of asynchronous pins.
module pin_sync #(
  parameter int               WIDTH   = 4,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_pin
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk) begin
      if (rst) pipe <= {STAGES{RST_VAL[g]}};
      else     pipe <= {pipe[STAGES-2:0], din[g]};
    end
    assign dout[g] = pipe[STAGES-1];
  end

endmodule

// File: rtl/hold_ctrl.sv
// Pause tracker: state changes only while the synchronised SCLK is low.
module hold_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic cs_s,
  input  logic hold_s,
  input  logic sclk_s,
  output logic hold_act
);

  always_ff @(posedge clk) begin
    if (rst || cs_s) begin
      hold_act <= 1'b0;
    end else if (!sclk_s) begin
      if (!hold_act && !hold_s)     hold_act <= 1'b1;
      else if (hold_act && hold_s)  hold_act <= 1'b0;
    end
  end

endmodule

// File: rtl/rom_pattern.sv
// Address-derived content: XOR of every byte lane of the address.
module rom_pattern #(
  parameter int ADDR_W = 24
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [7:0]        data
);

  localparam int LANES = ADDR_W / 8;

  always_comb begin
    data = '0;
    for (int b = 0; b < LANES; b++) data ^= addr[8*b +: 8];
  end

endmodule

// File: rtl/spi_rom_engine.sv
// Command sequencer: opcode, address, dummy and data phases.
module spi_rom_engine
  import spi_rom_pkg::*;
#(
  parameter int                    ADDR_W   = 24,
  parameter int                    ID_BYTES = 3,
  parameter logic [8*ID_BYTES-1:0] ID_VALUE = 24'hC2_05_18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_s,
  input  logic              si_s,
  input  logic              cs_s,
  input  logic              hold_act,
  input  logic [7:0]        fetch_byte,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              so_bit,
  output logic              drive,
  output eng_state_t        state
);

  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int ABC_W      = (ADDR_BYTES > 2) ? $clog2(ADDR_BYTES) : 1;
  localparam int IDX_W      = (ID_BYTES > 2) ? $clog2(ID_BYTES) : 1;

  logic              sclk_q, cs_q;
  logic [6:0]        shreg;
  logic [2:0]        bitcnt, obit;
  logic [ABC_W-1:0]  abc;
  logic [ADDR_W-1:0] addr;
  logic              fast, is_id;
  logic [IDX_W-1:0]  id_idx, id_nidx;
  logic [7:0]        txb;
  logic [7:0]        in_byte;
  logic [7:0]        id_lut [ID_BYTES];
  logic              rise_en, fall_en, cs_fall;

  for (genvar g = 0; g < ID_BYTES; g++) begin : g_id
    assign id_lut[g] = ID_VALUE[8*(ID_BYTES-1-g) +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      sclk_q <= sclk_s;
      cs_q   <= cs_s;
    end
  end

  assign rise_en = sclk_s & ~sclk_q & ~hold_act & ~cs_s;
  assign fall_en = ~sclk_s & sclk_q & ~hold_act & ~cs_s;
  assign cs_fall = ~cs_s & cs_q;
  assign in_byte = {shreg, si_s};
  assign id_nidx = (id_idx == IDX_W'(ID_BYTES-1)) ? '0 : id_idx + 1'b1;

  always_comb begin
    case (state)
      ST_ADDR: fetch_addr = {addr[ADDR_W-9:0], in_byte};
      ST_DATA: fetch_addr = addr + 1'b1;
      default: fetch_addr = addr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      shreg  <= '0;
      bitcnt <= '0;
      obit   <= '0;
      abc    <= '0;
      addr   <= '0;
      fast   <= 1'b0;
      is_id  <= 1'b0;
      id_idx <= '0;
      txb    <= '0;
      so_bit <= 1'b0;
      drive  <= 1'b0;
    end else if (cs_s) begin
      state  <= ST_IDLE;
      bitcnt <= '0;
      obit   <= '0;
      abc    <= '0;
      fast   <= 1'b0;
      is_id  <= 1'b0;
      id_idx <= '0;
      drive  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (cs_fall) state <= ST_OPCODE;

        ST_OPCODE, ST_ADDR, ST_DUMMY: if (rise_en) begin
          shreg  <= in_byte[6:0];
          bitcnt <= bitcnt + 3'd1;
          if (bitcnt == 3'd7) begin
            case (state)
              ST_OPCODE: begin
                case (in_byte)
                  OP_IDENT: begin
                    state  <= ST_DATA;
                    is_id  <= 1'b1;
                    id_idx <= '0;
                    txb    <= id_lut[0];
                    obit   <= '0;
                  end
                  OP_READ: begin
                    state <= ST_ADDR;
                    fast  <= 1'b0;
                  end
                  OP_FAST: begin
                    state <= ST_ADDR;
                    fast  <= 1'b1;
                  end
                  default: state <= ST_STANDBY;
                endcase
              end
              ST_ADDR: begin
                addr <= fetch_addr;
                abc  <= abc + 1'b1;
                if (abc == ABC_W'(ADDR_BYTES-1)) begin
                  if (fast) begin
                    state <= ST_DUMMY;
                  end else begin
                    state <= ST_DATA;
                    txb   <= fetch_byte;
                    obit  <= '0;
                  end
                end
              end
              default: begin
                state <= ST_DATA;
                txb   <= fetch_byte;
                obit  <= '0;
              end
            endcase
          end
        end

        ST_DATA: if (fall_en) begin
          so_bit <= txb[7];
          drive  <= 1'b1;
          obit   <= obit + 3'd1;
          if (obit == 3'd7) begin
            if (is_id) begin
              id_idx <= id_nidx;
              txb    <= id_lut[id_nidx];
            end else begin
              addr <= fetch_addr;
              txb  <= fetch_byte;
            end
          end else begin
            txb <= {txb[6:0], 1'b0};
          end
        end

        default: ;
      endcase
    end
  end

endmodule

// File: rtl/spi_rom_slave.sv
module spi_rom_slave
  import spi_rom_pkg::*;
#(
  parameter int                    ADDR_W      = 24,
  parameter int                    SYNC_STAGES = 2,
  parameter int                    ID_BYTES    = 3,
  parameter logic [8*ID_BYTES-1:0] ID_VALUE    = 24'hC2_05_18
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  input  logic si,
  input  logic cs_n,
  input  logic hold_n,
  output logic so_data,
  output logic so_oe
);

  logic              sclk_s, si_s, cs_s, hold_s;
  logic              hold_act;
  logic [ADDR_W-1:0] fetch_addr;
  logic [7:0]        fetch_byte;
  logic              so_bit, drive;
  eng_state_t        eng_state;

  pin_sync #(
    .WIDTH   (4),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (4'b1100)
  ) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({hold_n, cs_n, si, sclk}),
    .dout ({hold_s, cs_s, si_s, sclk_s})
  );

  hold_ctrl u_hold (
    .clk      (clk),
    .rst      (rst),
    .cs_s     (cs_s),
    .hold_s   (hold_s),
    .sclk_s   (sclk_s),
    .hold_act (hold_act)
  );

  rom_pattern #(.ADDR_W(ADDR_W)) u_rom (
    .addr (fetch_addr),
    .data (fetch_byte)
  );

  spi_rom_engine #(
    .ADDR_W   (ADDR_W),
    .ID_BYTES (ID_BYTES),
    .ID_VALUE (ID_VALUE)
  ) u_eng (
    .clk        (clk),
    .rst        (rst),
    .sclk_s     (sclk_s),
    .si_s       (si_s),
    .cs_s       (cs_s),
    .hold_act   (hold_act),
    .fetch_byte (fetch_byte),
    .fetch_addr (fetch_addr),
    .so_bit     (so_bit),
    .drive      (drive),
    .state      (eng_state)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      so_data <= 1'b0;
      so_oe   <= 1'b0;
    end else begin
      so_data <= so_bit;
      so_oe   <= drive & ~hold_act & ~cs_s;
    end
  end

endmodule

// File: rtl/spi_rom_chk.sv
module spi_rom_chk
  import spi_rom_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       sclk_s,
  input logic       cs_s,
  input logic       hold_act,
  input eng_state_t state,
  input logic       so_oe,
  input logic       so_data
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !so_oe);

  // R7
  deselect_idle_chk: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> (state == ST_IDLE) && !so_oe);

  // R6
  standby_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_STANDBY) |=> !so_oe);

  // R9
  hold_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    hold_act |=> !so_oe);

  // R9
  hold_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (hold_act && $past(hold_act) && $past(hold_act, 2)) |-> $stable(so_data));

  // R10
  hold_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_act) |-> $past(!sclk_s));

  // R10
  hold_end_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(hold_act) && !$past(cs_s)) |-> $past(!sclk_s));

endmodule

bind spi_rom_slave spi_rom_chk i_chk (
  .clk      (clk),
  .rst      (rst),
  .sclk_s   (sclk_s),
  .cs_s     (cs_s),
  .hold_act (hold_act),
  .state    (eng_state),
  .so_oe    (so_oe),
  .so_data  (so_data)
);

// File: tb/test_spi_rom_slave.sv
module test_spi_rom_slave;

  logic clk = 1'b0, rst = 1'b1;
  logic sclk = 1'b0, si = 1'b0, cs_n = 1'b1, hold_n = 1'b1;
  logic so_data, so_oe;

  localparam int H = 8;

  int nchk = 0, nerr = 0;

  typedef struct {
    logic [7:0] val;
    string      tag;
  } exp_t;
  exp_t        exp_q[$];
  exp_t        e;
  logic [7:0]  got;
  event        got_ev;
  logic [7:0]  id_ref [3] = '{8'hC2, 8'h05, 8'h18};

  always #5 clk = ~clk;

  spi_rom_slave i_spi_rom_slave (
    .clk (clk), .rst (rst), .sclk (sclk), .si (si),
    .cs_n (cs_n), .hold_n (hold_n), .so_data (so_data), .so_oe (so_oe)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  function automatic logic [7:0] rom(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16];
  endfunction

  task automatic wt(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // monitor / scoreboard
  initial forever begin
    @(got_ev);
    if (exp_q.size() == 0) begin
      check(1'b0, "R3", "unexpected byte", int'(got), 0);
    end else begin
      e = exp_q.pop_front();
      check(got == e.val, e.tag, "data byte", int'(got), int'(e.val));
    end
  end

  // driver: hold_kind 1 = hold with SCLK low, 2 = deferred start and end
  task automatic run_cmd(input bit m3, input logic [7:0] op, input logic [23:0] a,
                         input int nbytes, input int extra, input int hold_at,
                         input int hold_kind, input string tag);
    logic [39:0] hdr;
    logic [7:0]  acc;
    int          hb;
    hb  = (op == 8'h9F) ? 8 : (op == 8'h0B) ? 40 : 32;
    hdr = {op, a, 8'h00};
    acc = '0;
    for (int k = 0; k < nbytes; k++) begin
      exp_t x;
      x.val = (op == 8'h9F) ? id_ref[k % 3] : rom(24'(a + 24'(k)));
      x.tag = tag;
      exp_q.push_back(x);
    end
    sclk = m3; wt(H);
    cs_n = 1'b0; wt(H);
    for (int i = 0; i < hb + 8*nbytes + extra; i++) begin
      if (i == hold_at && hold_kind == 2) begin
        hold_n = 1'b0; wt(H);
        check(so_oe == 1'b1, "R10", "hold deferred while SCLK high", int'(so_oe), 1);
        sclk = 1'b0; wt(H);
        check(so_oe == 1'b0, "R10", "hold active after SCLK low", int'(so_oe), 0);
        sclk = 1'b1; wt(H);
        hold_n = 1'b1; wt(H);
        check(so_oe == 1'b0, "R10", "release deferred while SCLK high", int'(so_oe), 0);
      end
      sclk = 1'b0; wt(H);
      if (i == hold_at && hold_kind == 1) begin
        hold_n = 1'b0; wt(H);
        check(so_oe == 1'b0, "R9", "SO disabled in hold", int'(so_oe), 0);
        repeat (3) begin
          si = ~si; sclk = 1'b1; wt(H);
          sclk = 1'b0; wt(H);
        end
        check(so_oe == 1'b0, "R9", "SO disabled after SCLK toggles in hold", int'(so_oe), 0);
        hold_n = 1'b1; wt(H);
      end
      if (i >= hb) begin
        check(so_oe == 1'b1, tag, "SO enabled in data phase", int'(so_oe), 1);
        acc = {acc[6:0], so_data};
        if (((i - hb) % 8 == 7) && ((i - hb) < 8*nbytes)) begin
          got = acc;
          ->got_ev;
        end
      end
      si = (i < hb) ? hdr[39-i] : 1'b0;
      sclk = 1'b1; wt(H);
    end
    if (!m3) begin sclk = 1'b0; wt(H); end
    cs_n = 1'b1; wt(H);
    check(so_oe == 1'b0, "R7", "SO released after deselect", int'(so_oe), 0);
    sclk = m3; wt(H);
  endtask

  // R6: unknown opcode, then a read-like pattern that must be ignored
  task automatic standby_cmd(input bit m3);
    logic [47:0] pat;
    pat = {8'h5A, 8'h03, 24'h000100, 8'h00};
    sclk = m3; wt(H);
    cs_n = 1'b0; wt(H);
    for (int i = 0; i < 48; i++) begin
      sclk = 1'b0; wt(H);
      if (i >= 8) check(so_oe == 1'b0, "R6", "SO disabled in standby", int'(so_oe), 0);
      si = pat[47-i];
      sclk = 1'b1; wt(H);
    end
    sclk = 1'b0; wt(H);
    check(so_oe == 1'b0, "R6", "SO disabled in standby", int'(so_oe), 0);
    cs_n = 1'b1; wt(H);
  endtask

  // R11: chip select raised while a hold is active
  task automatic cs_hold_test();
    logic [31:0] hdr;
    hdr = {8'h03, 24'h400000};
    sclk = 1'b0; wt(H);
    cs_n = 1'b0; wt(H);
    for (int i = 0; i < 36; i++) begin
      sclk = 1'b0; wt(H);
      si = (i < 32) ? hdr[31-i] : 1'b0;
      sclk = 1'b1; wt(H);
    end
    sclk = 1'b0; wt(H);
    check(so_oe == 1'b1, "R11", "SO enabled before hold", int'(so_oe), 1);
    hold_n = 1'b0; wt(H);
    cs_n = 1'b1; wt(H);
    check(so_oe == 1'b0, "R11", "SO disabled after deselect in hold", int'(so_oe), 0);
    hold_n = 1'b1; wt(H);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
  endtask

  initial begin
    wt(5);
    check(so_oe == 1'b0, "R1", "SO disabled in reset", int'(so_oe), 0);
    rst = 1'b0; wt(5);
    check(so_oe == 1'b0, "R1", "SO disabled after reset", int'(so_oe), 0);

    run_cmd(1'b0, 8'h9F, 24'h0,      3, 0, -1, 0, "R2");
    run_cmd(1'b0, 8'h03, 24'h123456, 3, 0, -1, 0, "R3");
    run_cmd(1'b1, 8'h0B, 24'hABCDEF, 3, 0, -1, 0, "R4");
    run_cmd(1'b1, 8'h03, 24'hFFFFFE, 4, 0, -1, 0, "R5");
    run_cmd(1'b1, 8'h9F, 24'h0,      3, 0, -1, 0, "R8");
    run_cmd(1'b0, 8'h0B, 24'h00FFFF, 2, 0, -1, 0, "R8");

    standby_cmd(1'b0);
    run_cmd(1'b0, 8'h03, 24'h000777, 2, 0, -1, 0, "R6");

    run_cmd(1'b0, 8'h03, 24'h002040, 1, 3, -1, 0, "R7");
    run_cmd(1'b0, 8'h0B, 24'h000010, 2, 0, -1, 0, "R7");

    run_cmd(1'b0, 8'h03, 24'h5A5A00, 3, 0, 12, 1, "R9");
    run_cmd(1'b1, 8'h03, 24'h010203, 3, 0, 37, 1, "R9");

    run_cmd(1'b0, 8'h0B, 24'h00FF00, 3, 0, 45, 2, "R10");
    run_cmd(1'b1, 8'h0B, 24'h7F8081, 3, 0, 50, 2, "R10");

    cs_hold_test();
    run_cmd(1'b0, 8'h9F, 24'h0,      3, 0, -1, 0, "R11");

    wt(20);
    check(exp_q.size() == 0, "R3", "pending expected bytes", exp_q.size(), 0);
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL R1 watchdog expired: actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

endmodule